// File: doc/BRIEF.md
# Inter-Warp Stride Prefetcher

This block sits beside the first-level data cache of one GPU streaming multiprocessor and watches the loads that its warps issue. Each observed load carries the program counter of the load instruction, the issuing warp number, the base address and whether the cache hit. Loads from different warps at the same program counter often walk a large array indexed by thread number. Each address is touched once and the spacing is even, so the first touch by every warp misses. The block learns that spacing per program counter. The spacing is measured between warps, not between successive accesses of one warp.

When a new warp reaches a trained program counter and misses, the block predicts where other warps will load at that program counter. It queues cache-line-aligned prefetch requests for those addresses. The warps to predict for are either the next two warp numbers or two warps named by the scheduler. Program counters whose warps all load one address are marked as short-range and never prefetched. Requests leave through a valid/ready stream. A request stays at the output, unchanged, until the consumer takes it. New requests that find the queue full are discarded rather than stalling anything. The load observation input has no ready signal: it is a tap that never back-pressures the cache, and loads the block cannot take are simply not learned from.

Top module: `warp_stride_pf`

## Requirements
- R1: After reset the tracking table is empty, the request queue is empty and `pf_valid` is 0.
- R2: The table holds 16 entries, looked up by program counter with full associativity. A load with an unknown program counter takes the least recently used entry, with stride 0, confidence 0 and its warp and address recorded. Every accepted load touches its entry, and an evicted program counter loses all that it learned.
- R3: A load at a known program counter from a different warp computes stride = (address − stored address) / (warp − stored warp). Both differences are signed and the division truncates. A load from the same warp as the stored one changes nothing but recency.
- R4: Confidence is 2 bits. An exact, non-zero stride equal to the stored one raises it, saturating at 3. A different exact stride lowers it, saturating at 0, and replaces the stored stride. A non-zero remainder sets it to 0 and leaves the stride unchanged. In every case the entry then records the new warp and address.
- R5: An exact stride of 0 marks the program counter as short-range, sets confidence to 0, and stops all further prefetching for that program counter while its entry lives.
- R6: After a stride update, a missing load fires prefetches if confidence is now 2 or more and the entry is not short-range. For each target warp T, the predicted address is address + stride × (T − warp), taken modulo 2^32. Without scheduler input the targets are warp+1 and warp+2, modulo 64.
- R7: If `sched_valid` is 1 in the cycle the stride result is applied, the targets are `sched_warps[5:0]` (first) and `sched_warps[11:6]` (second) instead.
- R8: Every issued address is the predicted address with its low 7 bits cleared (128-byte lines).
- R9: A candidate is suppressed if its line equals the demand line, a line already in the queue, or the line of the first candidate.
- R10: The queue holds 4 requests. Surviving candidates are taken in target order while free slots remain, and a slot freed in the same cycle does not count; the rest are discarded.
- R11: The divider takes 32 cycles. A load that starts a division in cycle t blocks loads in cycles t+1 to t+33. Those loads are ignored completely; the result is applied at the end of cycle t+33.
- R12: `pf_valid` and `pf_addr` hold steady until `pf_ready` is 1. Requests leave in the order they were queued.
- R13: A load that hits still trains stride and confidence but never fires prefetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | An observed load is present this cycle |
| ld_pc | input | 32 | Program counter of the load |
| ld_warp | input | 6 | Issuing warp number |
| ld_addr | input | 32 | Base byte address of the load |
| ld_hit | input | 1 | 1 if the cache hit, 0 on a miss |
| sched_valid | input | 1 | Scheduler warp list below is valid |
| sched_warps | input | 12 | Two upcoming warp numbers, first in the low bits |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the offered request |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
Two things can happen in the same cycle: a stride result can push new requests into the queue while the consumer pops the head. That cycle also decides both whether a candidate duplicates a queued line and whether a slot is free. The bench holds `pf_ready` low across several trained misses until the queue fills, then toggles it around completion cycles. It also times loads to arrive exactly in the last blocked cycle and in the first open one. A behavioural reference model runs alongside, with a list for the table and a queue for requests. On every clock the model's head request and valid flag are compared with the ports.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX  = '1;
  localparam logic [CONF_W-1:0] CONF_FIRE = 2'd2;
endpackage

// File: rtl/wsp_divider.sv
// Iterative signed divider: one quotient bit per cycle, truncating toward zero.
module wsp_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [NUM_W-1:0] num,
  input  logic signed [DEN_W-1:0] den,
  output logic                    busy,
  output logic                    done,
  output logic signed [NUM_W-1:0] quo,
  output logic                    rem_nz
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] rem_r, dmag_r;
  logic             neg_r;
  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] nmag;
  logic [DEN_W-1:0] dmag;
  logic [DEN_W:0]   shifted;
  logic             take;

  always_comb begin
    nmag    = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
    dmag    = den[DEN_W-1] ? DEN_W'(-den) : DEN_W'(den);
    shifted = {rem_r, q_r[NUM_W-1]};
    take    = shifted >= {1'b0, dmag_r};
    quo     = neg_r ? -$signed(q_r) : $signed(q_r);
    rem_nz  = |rem_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0; rem_r <= '0; dmag_r <= '0; neg_r <= 1'b0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r    <= nmag;
        rem_r  <= '0;
        dmag_r <= dmag;
        neg_r  <= num[NUM_W-1] ^ den[DEN_W-1];
        cnt    <= CNT_W'(NUM_W);
        busy   <= 1'b1;
      end else if (busy) begin
        rem_r <= take ? DEN_W'(shifted - {1'b0, dmag_r}) : DEN_W'(shifted);
        q_r   <= {q_r[NUM_W-2:0], take};
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R11: a division never restarts while one is running or completing
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy && !done));
  // R11: completion is always preceded by the busy phase
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/wsp_req_queue.sv
// Prefetch request FIFO with several push ports per cycle and visible slots.
module wsp_req_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int NPUSH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPUSH-1:0]  push_en,
  input  logic [DATA_W-1:0] push_data [NPUSH],
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [$clog2(DEPTH):0] count,
  output logic [DATA_W-1:0] slot_data [DEPTH],
  output logic [DEPTH-1:0]  slot_occ
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [PTR_W-1:0]  wr_idx [NPUSH];
  logic [PTR_W:0]    n_push;

  always_comb begin
    n_push = '0;
    for (int k = 0; k < NPUSH; k++) begin
      wr_idx[k] = wr_ptr + n_push[PTR_W-1:0];
      n_push    = n_push + (PTR_W+1)'(push_en[k]);
    end
    for (int s = 0; s < DEPTH; s++) begin
      slot_data[s] = mem[s];
      slot_occ[s]  = {1'b0, PTR_W'(s) - rd_ptr} < count;
    end
    head = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; count <= '0;
      for (int s = 0; s < DEPTH; s++) mem[s] <= '0;
    end else begin
      for (int k = 0; k < NPUSH; k++)
        if (push_en[k]) mem[wr_idx[k]] <= push_data[k];
      wr_ptr <= wr_ptr + n_push[PTR_W-1:0];
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + n_push - (PTR_W+1)'(pop);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PTR_W+1)'(DEPTH));
  a_r12_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/warp_stride_pf.sv
module warp_stride_pf
  import wsp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int WID_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 128,
  parameter int QDEPTH     = 4,
  parameter int NPF        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [PC_W-1:0]        ld_pc,
  input  logic [WID_W-1:0]       ld_warp,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic                   ld_hit,
  input  logic                   sched_valid,
  input  logic [NPF*WID_W-1:0]   sched_warps,
  output logic                   pf_valid,
  input  logic                   pf_ready,
  output logic [ADDR_W-1:0]      pf_addr
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int QCNT_W = $clog2(QDEPTH) + 1;
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  // tracking table
  logic              t_vld    [ENTRIES];
  logic [PC_W-1:0]   t_pc     [ENTRIES];
  logic [WID_W-1:0]  t_warp   [ENTRIES];
  logic [ADDR_W-1:0] t_addr   [ENTRIES];
  logic [ADDR_W-1:0] t_stride [ENTRIES];
  logic [CONF_W-1:0] t_conf   [ENTRIES];
  logic              t_short  [ENTRIES];
  logic [IDX_W-1:0]  t_age    [ENTRIES];

  // pending update held while the divider runs
  logic [IDX_W-1:0]  p_idx;
  logic [WID_W-1:0]  p_warp;
  logic [ADDR_W-1:0] p_addr;
  logic              p_hit;

  logic              hit_any, accept, need_div;
  logic [IDX_W-1:0]  hit_idx, victim_idx, sel_idx;
  logic              div_busy, div_done, div_rem_nz;
  logic signed [ADDR_W-1:0] div_quo;
  logic signed [WID_W:0]    warp_gap;

  always_comb begin
    hit_any = 1'b0; hit_idx = '0; victim_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (t_vld[i] && t_pc[i] == ld_pc) begin hit_any = 1'b1; hit_idx = IDX_W'(i); end
      if (t_age[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
    accept   = ld_valid && !div_busy && !div_done;
    sel_idx  = hit_any ? hit_idx : victim_idx;
    need_div = accept && hit_any && (t_warp[hit_idx] != ld_warp);
    warp_gap = $signed({1'b0, ld_warp}) - $signed({1'b0, t_warp[hit_idx]});
  end

  wsp_divider #(.NUM_W(ADDR_W), .DEN_W(WID_W + 1)) i_div (
    .clk(clk), .rst_n(rst_n), .start(need_div),
    .num($signed(ld_addr - t_addr[hit_idx])), .den(warp_gap),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem_nz(div_rem_nz)
  );

  // stride / confidence outcome when the division completes
  logic [ADDR_W-1:0] new_stride;
  logic [CONF_W-1:0] new_conf;
  logic              new_short, fire;

  always_comb begin
    new_stride = t_stride[p_idx];
    new_conf   = '0;
    new_short  = t_short[p_idx];
    if (!div_rem_nz) begin
      new_stride = div_quo;
      if (div_quo == '0)
        new_short = 1'b1;
      else if (div_quo == t_stride[p_idx])
        new_conf = (t_conf[p_idx] == CONF_MAX) ? CONF_MAX : t_conf[p_idx] + 1'b1;
      else
        new_conf = (t_conf[p_idx] == '0) ? '0 : t_conf[p_idx] - 1'b1;
    end
    fire = div_done && !p_hit && !div_rem_nz && !new_short && (new_conf >= CONF_FIRE);
  end

  // address prediction, one multiplier lane per candidate
  logic [ADDR_W-1:0] cand [NPF];
  logic [NPF-1:0]    cand_ok, push_en;
  logic [ADDR_W-1:0] q_slot [QDEPTH];
  logic [QDEPTH-1:0] q_occ;
  logic [QCNT_W-1:0] q_count;
  logic [ADDR_W-1:0] demand_line;

  assign demand_line = p_addr & ~LINE_MASK;

  for (genvar k = 0; k < NPF; k++) begin : g_lane
    logic [WID_W-1:0]         tgt;
    logic signed [WID_W:0]    tdiff;
    logic signed [ADDR_W-1:0] tdiff_x, prod;
    logic                     dup;
    always_comb begin
      tgt     = sched_valid ? sched_warps[k*WID_W +: WID_W] : p_warp + WID_W'(k + 1);
      tdiff   = $signed({1'b0, tgt}) - $signed({1'b0, p_warp});
      tdiff_x = ADDR_W'(tdiff);
      prod    = div_quo * tdiff_x;
      cand[k] = (p_addr + prod) & ~LINE_MASK;
      dup     = (cand[k] == demand_line);
      for (int s = 0; s < QDEPTH; s++)
        if (q_occ[s] && q_slot[s] == cand[k]) dup = 1'b1;
      for (int j = 0; j < k; j++)
        if (cand[j] == cand[k]) dup = 1'b1;
      cand_ok[k] = fire && !dup;
    end
  end

  always_comb begin
    int used;
    used    = 0;
    push_en = '0;
    for (int k = 0; k < NPF; k++)
      if (cand_ok[k] && used < (QDEPTH - int'(q_count))) begin
        push_en[k] = 1'b1;
        used++;
      end
  end

  wsp_req_queue #(.DATA_W(ADDR_W), .DEPTH(QDEPTH), .NPUSH(NPF)) i_queue (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_data(cand),
    .pop(pf_valid && pf_ready), .head(pf_addr), .count(q_count),
    .slot_data(q_slot), .slot_occ(q_occ)
  );
  assign pf_valid = (q_count != '0);

  // table, recency and pending state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_vld[i] <= 1'b0; t_pc[i] <= '0; t_warp[i] <= '0; t_addr[i] <= '0;
        t_stride[i] <= '0; t_conf[i] <= '0; t_short[i] <= 1'b0;
        t_age[i] <= IDX_W'(i);
      end
      p_idx <= '0; p_warp <= '0; p_addr <= '0; p_hit <= 1'b0;
    end else begin
      if (accept) begin
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == sel_idx) t_age[i] <= '0;
          else if (t_age[i] < t_age[sel_idx]) t_age[i] <= t_age[i] + 1'b1;
        if (!hit_any) begin
          t_vld[victim_idx] <= 1'b1;       t_pc[victim_idx] <= ld_pc;
          t_warp[victim_idx] <= ld_warp;   t_addr[victim_idx] <= ld_addr;
          t_stride[victim_idx] <= '0;      t_conf[victim_idx] <= '0;
          t_short[victim_idx] <= 1'b0;
        end
      end
      if (need_div) begin
        p_idx <= hit_idx; p_warp <= ld_warp; p_addr <= ld_addr; p_hit <= ld_hit;
      end
      if (div_done) begin
        t_warp[p_idx] <= p_warp;         t_addr[p_idx] <= p_addr;
        t_stride[p_idx] <= new_stride;   t_conf[p_idx] <= new_conf;
        t_short[p_idx] <= new_short;
      end
    end
  end

  a_r12_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));
  a_r8_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ((pf_addr & LINE_MASK) == '0));
  a_r13_push_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (|push_en) |-> (div_done && !p_hit));
  a_r5_short_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (|push_en) |-> !t_short[p_idx]);
endmodule

// File: tb/test_warp_stride_pf.sv
`timescale 1ns/1ps
module test_warp_stride_pf;
  localparam int AW = 32, WW = 6, NE = 16, QD = 4;
  localparam longint AMASK = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_hit = 1'b0, sched_valid = 1'b0, pf_ready = 1'b1;
  logic [31:0] ld_pc = '0, ld_addr = '0;
  logic [WW-1:0] ld_warp = '0;
  logic [2*WW-1:0] sched_warps = '0;
  logic pf_valid;
  logic [AW-1:0] pf_addr;

  warp_stride_pf i_warp_stride_pf (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_warp(ld_warp),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .sched_valid(sched_valid),
    .sched_warps(sched_warps), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  longint m_pc [NE], m_la [NE], m_st [NE];
  int     m_lw [NE], m_cf [NE];
  bit     m_sh [NE];
  int     m_n = 0, cd = 0;
  longint m_q [$];
  longint p_addr; int p_warp; bit p_hit;

  function automatic longint s32(longint v);
    v = v & AMASK;
    if (v >= 64'h8000_0000) v = v - 64'h1_0000_0000;
    return v;
  endfunction

  task automatic m_copy(int d, int s);
    m_pc[d] = m_pc[s]; m_la[d] = m_la[s]; m_st[d] = m_st[s];
    m_lw[d] = m_lw[s]; m_cf[d] = m_cf[s]; m_sh[d] = m_sh[s];
  endtask

  task automatic m_front(int idx);
    longint a, b, c; int d, e; bit f;
    a = m_pc[idx]; b = m_la[idx]; c = m_st[idx]; d = m_lw[idx]; e = m_cf[idx]; f = m_sh[idx];
    for (int j = idx; j > 0; j--) m_copy(j, j - 1);
    m_pc[0] = a; m_la[0] = b; m_st[0] = c; m_lw[0] = d; m_cf[0] = e; m_sh[0] = f;
  endtask

  task automatic m_accept();
    int found = -1;
    for (int j = 0; j < m_n; j++) if (m_pc[j] == longint'(ld_pc)) found = j;
    if (found >= 0) begin
      m_front(found);
      if (m_lw[0] != int'(ld_warp)) begin
        cd = AW + 1; p_addr = ld_addr; p_warp = ld_warp; p_hit = ld_hit;
      end
    end else begin
      if (m_n < NE) m_n++;
      for (int j = m_n - 1; j > 0; j--) m_copy(j, j - 1);
      m_pc[0] = ld_pc; m_la[0] = ld_addr; m_st[0] = 0;
      m_lw[0] = ld_warp; m_cf[0] = 0; m_sh[0] = 0;
    end
  endtask

  task automatic m_complete(int free);
    longint a, q, r, pred, c0, line; int b, tw, pushed; bit dup, trig;
    a = s32(p_addr - m_la[0]);
    b = p_warp - m_lw[0];
    q = a / b; r = a % b;
    if (r != 0) m_cf[0] = 0;
    else begin
      if (q == 0) begin m_sh[0] = 1; m_cf[0] = 0; end
      else if (q == m_st[0]) m_cf[0] = (m_cf[0] == 3) ? 3 : m_cf[0] + 1;
      else m_cf[0] = (m_cf[0] == 0) ? 0 : m_cf[0] - 1;
      m_st[0] = q;
    end
    m_lw[0] = p_warp; m_la[0] = p_addr;
    trig = !p_hit && r == 0 && !m_sh[0] && m_cf[0] >= 2;
    pushed = 0; c0 = -1;
    if (trig) for (int k = 0; k < 2; k++) begin
      tw   = sched_valid ? int'(sched_warps[k*WW +: WW]) : (p_warp + k + 1) % 64;
      pred = (p_addr + q * longint'(tw - p_warp)) & AMASK;
      line = pred & ~longint'(127);
      dup  = (line == (p_addr & ~longint'(127))) || (k == 1 && line == c0);
      foreach (m_q[i]) if (m_q[i] == line) dup = 1;
      if (k == 0) c0 = line;
      if (!dup && pushed < free) begin m_q.push_back(line); pushed++; end
    end
  endtask

  task automatic model_step();
    bit popnow; int free;
    popnow = (m_q.size() > 0) && pf_ready;
    free   = QD - m_q.size();
    if (cd > 0) begin
      cd--;
      if (cd == 0) m_complete(free);
    end else if (ld_valid) m_accept();
    if (popnow) void'(m_q.pop_front());
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_n = 0; cd = 0; m_q.delete(); end
    else model_step();
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev; ev = m_q.size() > 0;
      n_cmp++;
      if (pf_valid !== ev || (ev && pf_addr !== AW'(m_q[0]))) begin
        n_bad++;
        $display("FAIL %s: cycle %0d got valid=%0b addr=%h expected valid=%0b addr=%h",
                 cur_req, cyc, pf_valid, pf_addr, ev, ev ? AW'(m_q[0]) : '0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic load(input logic [31:0] pc, input int w, input logic [31:0] a,
                      input bit h, input int gap);
    ld_valid = 1; ld_pc = pc; ld_warp = WW'(w); ld_addr = a; ld_hit = h;
    @(negedge clk);
    ld_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  localparam int G = AW + 3;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (pf_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: pf_valid got %0b expected 0", pf_valid);
    end
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R6 R8 R13: positive stride, a hit trains, same-warp repeat ignored
    cur_req = "R6";
    load(32'h100, 0, 32'h10000, 0, 2);
    load(32'h100, 1, 32'h10200, 0, G);
    cur_req = "R13";
    load(32'h100, 2, 32'h10400, 1, G);
    cur_req = "R4";
    load(32'h100, 3, 32'h10600, 0, G);
    cur_req = "R3";
    load(32'h100, 3, 32'h99999, 0, 2);
    load(32'h100, 4, 32'h10800, 0, G);
    cur_req = "R13";
    load(32'h100, 5, 32'h10A00, 1, G);

    // R9: stride inside one line, queued-line duplicates while stalled
    cur_req = "R9";
    pf_ready = 0;
    for (int w = 0; w < 5; w++) load(32'h200, w, 32'h20000 + 32 * w, 0, G);
    pf_ready = 1; repeat (6) @(negedge clk);

    // R7: scheduler-named warps, warp gap of 2
    cur_req = "R7";
    sched_warps = {6'd20, 6'd30};
    for (int w = 10; w <= 16; w += 2) begin
      sched_valid = (w == 16);
      load(32'h300, w, 32'h300000 + 32'h1000 * w, 0, G);
    end
    sched_valid = 0;
    // R6: negative stride
    cur_req = "R6";
    for (int w = 0; w < 4; w++) load(32'h350, w, 32'h80000 - 32'h300 * w, 0, G);

    // R5: zero stride then sticky short-range
    cur_req = "R5";
    for (int w = 0; w < 4; w++) load(32'h400, w, 32'h40000, 0, G);
    for (int w = 4; w < 8; w++) load(32'h400, w, 32'h40000 + 32'h400 * (w - 3), 0, G);

    // R4: inexact division resets confidence
    cur_req = "R4";
    for (int w = 0; w < 4; w++) load(32'h500, w, 32'h50000 + 32'h100 * w, 0, G);
    load(32'h500, 6, 32'h50400, 0, G);
    load(32'h500, 7, 32'h50500, 0, G);

    // R10 R12: fill the queue while stalled, then drain with toggling ready
    cur_req = "R10";
    pf_ready = 0;
    for (int w = 0; w < 8; w++) load(32'h600, w, 32'h60000 + 32'h400 * w, 0, G);
    cur_req = "R12";
    for (int i = 0; i < 12; i++) begin pf_ready = i[0]; @(negedge clk); end
    pf_ready = 1;
    for (int w = 8; w < 11; w++) begin
      pf_ready = w[0];
      load(32'h600, w, 32'h60000 + 32'h400 * w, 0, G);
    end
    pf_ready = 1; repeat (6) @(negedge clk);

    // R2: eviction after 16 other program counters
    cur_req = "R2";
    for (int w = 0; w < 4; w++) load(32'h700, w, 32'h70000 + 32'h800 * w, 0, G);
    for (int p = 0; p < 16; p++) load(32'h1000 + p * 4, 1, 32'h1000 * p, 0, 1);
    load(32'h700, 4, 32'h72000, 0, G);
    load(32'h700, 5, 32'h72800, 0, G);
    // R2: recency touch keeps an entry
    for (int w = 0; w < 3; w++) load(32'h780, w, 32'h78000 + 32'h100 * w, 0, G);
    for (int p = 0; p < 15; p++) load(32'h2000 + p * 4, 1, 32'h100 * p, 0, 1);
    load(32'h780, 3, 32'h78300, 0, G);

    // R11: loads at the last blocked cycle and the first open cycle
    cur_req = "R11";
    load(32'h800, 0, 32'h90000, 0, 2);
    load(32'h800, 1, 32'h90100, 0, G);
    load(32'h800, 2, 32'h90200, 0, AW);
    load(32'h800, 3, 32'h90300, 0, 0);
    load(32'h800, 4, 32'h90400, 0, 5);
    load(32'h800, 5, 32'h90500, 0, G);
    load(32'h800, 6, 32'h90600, 0, G);
    load(32'h800, 7, 32'h90700, 0, G);
    repeat (10) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule